// File: doc/BRIEF.md
# Packed Uniform Vector Loader

This block sits between a register write bus and a uniform memory of four-component vectors. Each component is a 24-bit float. Software first writes a setup word. That word picks the incoming number format and the vector slot where writing starts. Software then streams data words to a small window of aliased data addresses. The block stages the words. When it has enough of them for one vector, it builds that vector and issues a single write into the uniform memory. It then steps the slot index forward, so consecutive vectors can be streamed without rewriting the setup word.

There are two formats.

- **Single-precision format:** four 32-bit IEEE floats make one vector. Each float is narrowed to the 24-bit layout: 1 sign bit, a 7-bit exponent biased by 63, and a 16-bit mantissa. The first word lands in the highest component.
- **Packed format:** three words carry four 24-bit floats laid end to end. Some of those floats straddle word boundaries.

A slot index beyond the memory depth does not write. Instead the block pulses an error output.

Top module: `uvl_loader`

## Requirements
- R1: A bus write to any of the eight data addresses (8 to 15) appends its word to the staging buffer. A bus write to any address other than 0 and 8 to 15 changes no state and produces no output.
- R2: In single-precision mode (setup bit 31 = 1), a vector completes on the 4th staged word. Component c of the vector occupies mem_wdata[24c+23:24c], where x is c=0 and w is c=3. Component c is the converted value of staged word 3-c, so word 0 becomes w and word 3 becomes x.
- R3: In packed mode (setup bit 31 = 0), a vector completes on the 3rd staged word. With words 0, 1 and 2 in arrival order, mem_wdata equals {word0, word1, word2}. That places w = word0[31:8], z = {word0[7:0], word1[31:16]}, y = {word1[15:0], word2[31:24]} and x = word2[23:0].
- R4: Single-precision conversion produces sign, then exponent minus 64 in 7 bits, then the top 16 mantissa bits (the rest are truncated), when the input exponent field lies in 65..191.
- R5: An input exponent field of 64 or less, including zero and subnormals, converts to a signed zero (sign bit kept, other 23 bits 0).
- R6: An input exponent field of 192 or more, including infinities and NaNs, saturates to sign followed by 23 one bits.
- R7: Each completed vector whose slot index is 0..95 is written to mem_addr equal to that index, and the index then increments by one.
- R8: A completed vector whose index is 96 or more is not written. Instead idx_err pulses for one cycle, the staging count clears, and the index is left unchanged.
- R9: A write to setup address 0 loads the index from bits 6:0 and the format from bit 31. It also discards any partially staged words.
- R10: mem_we and idx_err are registered single-cycle pulses. They are high in the cycle after the edge that samples the completing word. Reset clears both, sets the index to 0 and selects packed format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register write address |
| bus_wdata | input | 32 | Register write data |
| mem_we | output | 1 | Uniform memory write strobe |
| mem_addr | output | 7 | Uniform memory slot index |
| mem_wdata | output | 96 | Assembled vector, x in the low 24 bits |
| idx_err | output | 1 | Pulse: completed vector rejected for an out-of-range index |

## Verification
The bench targets the following corner cases and the failure each one would expose:

- **Component reversal in single-precision mode.** A design that skipped the reversal would put word 0 into x.
- **Word straddling in packed mode.** A mis-sliced unpack would shift bits between z and y.
- **Exponent edges 64/65 and 191/192.** These catch an off-by-one in the flush or saturation thresholds.
- **Slots 95 and 96.** A wrong range check would either write slot 96 or reject 95. An index that kept counting after a rejection would wrap back into range.
- **Setup write in the middle of a vector.** A design that failed to discard the staged words would commit a vector mixing stale and new words.
- **Writes to undecoded addresses.** A design that decoded these as data would complete vectors early.

// File: rtl/uvl_pkg.sv
package uvl_pkg;
  localparam int WORD_W   = 32;
  localparam int CMP_W    = 24;
  localparam int NCMP     = 4;
  localparam int VEC_W    = CMP_W * NCMP;
  localparam int F32_E    = 8;
  localparam int F32_M    = 23;
  localparam int F32_BIAS = 127;
  localparam int F24_E    = 7;
  localparam int F24_M    = 16;
  localparam int F24_BIAS = 63;

  typedef enum logic {
    FMT_PACKED = 1'b0,
    FMT_F32    = 1'b1
  } fmt_e;
endpackage

// File: rtl/uvl_f32_to_f24.sv
// Narrows one IEEE single into the 24-bit uniform float layout.
module uvl_f32_to_f24
  import uvl_pkg::*;
(
  input  logic [WORD_W-1:0] f_in,
  output logic [CMP_W-1:0]  h_out
);
  localparam int SHIFT   = F32_BIAS - F24_BIAS;
  localparam int EXP_TOP = (1 << F24_E) - 1;

  logic             sgn;
  logic [F32_E-1:0] e_in;
  logic [F32_M-1:0] m_in;
  logic             unused_lsb;
  int               e_reb;

  assign sgn        = f_in[WORD_W-1];
  assign e_in       = f_in[F32_M +: F32_E];
  assign m_in       = f_in[F32_M-1:0];
  assign unused_lsb = ^m_in[F32_M-F24_M-1:0];

  always_comb begin
    e_reb = int'(e_in) - SHIFT;
    if (e_reb <= 0)
      h_out = {sgn, {(CMP_W-1){1'b0}}};
    else if (e_reb > EXP_TOP)
      h_out = {sgn, {(CMP_W-1){1'b1}}};
    else
      h_out = {sgn, e_reb[F24_E-1:0], m_in[F32_M-1 -: F24_M]};
  end
endmodule

// File: rtl/uvl_stage.sv
// Holds all but the final word of a vector; flags the completing push.
module uvl_stage #(
  parameter  int WORD_W = 32,
  parameter  int HOLD   = 3,
  localparam int CNT_W  = $clog2(HOLD + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       push,
  input  logic [WORD_W-1:0]          word,
  input  logic [CNT_W-1:0]           last_slot,
  output logic                       done,
  output logic [HOLD-1:0][WORD_W-1:0] held
);
  logic [CNT_W-1:0] cnt;

  assign done = push && (cnt == last_slot);

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (push)
      cnt <= done ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < HOLD; s++) begin
      if (push && !done && cnt == CNT_W'(s))
        held[s] <= word;
    end
  end
endmodule

// File: rtl/uvl_assemble.sv
// Builds the 96-bit vector from the staged words in either format.
module uvl_assemble
  import uvl_pkg::*;
(
  input  fmt_e                          fmt,
  input  logic [NCMP-1:0][WORD_W-1:0]   words,
  output logic [VEC_W-1:0]              vec
);
  logic [NCMP-1:0][CMP_W-1:0] conv;
  logic [VEC_W-1:0]           stream;

  // Single-precision: component c takes word NCMP-1-c (reversed order).
  for (genvar c = 0; c < NCMP; c++) begin : g_conv
    uvl_f32_to_f24 u_cvt (
      .f_in (words[NCMP-1-c]),
      .h_out(conv[c])
    );
  end

  // Packed: first word occupies the top of the vector.
  for (genvar k = 0; k < NCMP - 1; k++) begin : g_pack
    assign stream[(NCMP-2-k)*WORD_W +: WORD_W] = words[k];
  end

  assign vec = (fmt == FMT_F32) ? conv : stream;
endmodule

// File: rtl/uvl_loader.sv
module uvl_loader
  import uvl_pkg::*;
#(
  parameter  int ADDR_W     = 4,
  parameter  int SETUP_ADDR = 0,
  parameter  int DATA_BASE  = 8,
  parameter  int N_ALIAS    = 8,
  parameter  int DEPTH      = 96,
  parameter  int IDX_W      = 7,
  parameter  int FMT_BIT    = 31,
  localparam int HOLD       = NCMP - 1,
  localparam int CNT_W      = $clog2(HOLD + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic              mem_we,
  output logic [IDX_W-1:0]  mem_addr,
  output logic [VEC_W-1:0]  mem_wdata,
  output logic              idx_err
);
  logic                         setup_hit, data_hit;
  fmt_e                         fmt_q;
  logic [IDX_W-1:0]             idx_q;
  logic [CNT_W-1:0]             last_slot;
  logic                         done, in_range;
  logic [HOLD-1:0][WORD_W-1:0]  held;
  logic [NCMP-1:0][WORD_W-1:0]  words;
  logic [VEC_W-1:0]             vec;

  assign setup_hit = bus_we && (int'(bus_addr) == SETUP_ADDR);
  assign data_hit  = bus_we && (int'(bus_addr) >= DATA_BASE) &&
                     (int'(bus_addr) < DATA_BASE + N_ALIAS);

  assign last_slot = (fmt_q == FMT_F32) ? CNT_W'(NCMP - 1) : CNT_W'(NCMP - 2);
  assign in_range  = int'(idx_q) < DEPTH;

  uvl_stage #(.WORD_W(WORD_W), .HOLD(HOLD)) u_stage (
    .clk      (clk),
    .rst      (rst),
    .clr      (setup_hit),
    .push     (data_hit),
    .word     (bus_wdata),
    .last_slot(last_slot),
    .done     (done),
    .held     (held)
  );

  // The completing word bypasses the buffer straight into its slot.
  for (genvar i = 0; i < HOLD; i++) begin : g_words
    assign words[i] = (CNT_W'(i) == last_slot) ? bus_wdata : held[i];
  end
  assign words[NCMP-1] = bus_wdata;

  uvl_assemble u_asm (
    .fmt  (fmt_q),
    .words(words),
    .vec  (vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we  <= 1'b0;
      idx_err <= 1'b0;
      idx_q   <= '0;
      fmt_q   <= FMT_PACKED;
    end else begin
      mem_we  <= done && in_range;
      idx_err <= done && !in_range;
      if (setup_hit) begin
        idx_q <= bus_wdata[IDX_W-1:0];
        fmt_q <= fmt_e'(bus_wdata[FMT_BIT]);
      end else if (done && in_range) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (done) begin
      mem_addr  <= idx_q;
      mem_wdata <= vec;
    end
  end
endmodule

// File: rtl/uvl_loader_chk.sv
module uvl_loader_chk #(
  parameter int ADDR_W     = 4,
  parameter int SETUP_ADDR = 0,
  parameter int DEPTH      = 96,
  parameter int IDX_W      = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              mem_we,
  input logic [IDX_W-1:0]  mem_addr,
  input logic              idx_err
);
  assert_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && idx_err));

  assert_addr_range_R8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (int'(mem_addr) < DEPTH));

  assert_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  assert_err_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    idx_err |=> !idx_err);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !bus_we |=> (!mem_we && !idx_err));

  assert_setup_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_we && int'(bus_addr) == SETUP_ADDR) |=> (!mem_we && !idx_err));
endmodule

bind uvl_loader uvl_loader_chk #(
  .ADDR_W(ADDR_W), .SETUP_ADDR(SETUP_ADDR), .DEPTH(DEPTH), .IDX_W(IDX_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .bus_we  (bus_we),
  .bus_addr(bus_addr),
  .mem_we  (mem_we),
  .mem_addr(mem_addr),
  .idx_err (idx_err)
);

// File: tb/tb_uvl_loader.sv
`timescale 1ns/1ps
module tb_uvl_loader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        mem_we;
  logic [6:0]  mem_addr;
  logic [95:0] mem_wdata;
  logic        idx_err;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // bench model
  int          m_idx = 0;
  bit          m_f32 = 0;
  int          m_cnt = 0;
  logic [31:0] m_w [4];

  always #5 clk = ~clk;

  uvl_loader dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .idx_err(idx_err)
  );

  task automatic chk(bit ok, string req, logic [95:0] act, logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] to24(logic [31:0] f);
    int ex;
    ex = int'(f[30:23]);
    if (ex <= 64)       return {f[31], 23'h0};
    else if (ex >= 192) return {f[31], 23'h7FFFFF};
    else                return {f[31], 7'(ex - 64), f[22:7]};
  endfunction

  function automatic logic [95:0] model_vec();
    logic [95:0] v;
    if (m_f32) begin
      for (int c = 0; c < 4; c++) v[24*c +: 24] = to24(m_w[3-c]);
    end else begin
      v = {m_w[0], m_w[1], m_w[2]};
    end
    return v;
  endfunction

  // Drive one bus write, then check outputs on the following falling edge.
  task automatic wr(logic [3:0] a, logic [31:0] d);
    bit          exp_we = 0, exp_err = 0;
    int          exp_addr = 0;
    logic [95:0] exp_v = '0;
    string       dreq;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    if (a == 4'd0) begin
      m_idx = int'(d[6:0]); m_f32 = d[31]; m_cnt = 0;
    end else if (a >= 4'd8) begin
      m_w[m_cnt] = d; m_cnt++;
      if (m_cnt == (m_f32 ? 4 : 3)) begin
        m_cnt = 0;
        if (m_idx < 96) begin
          exp_we = 1; exp_addr = m_idx; exp_v = model_vec(); m_idx++;
        end else begin
          exp_err = 1;
        end
      end
    end
    chk(mem_we == exp_we, "R10 mem_we timing (R1/R9 decode)", 96'(mem_we), 96'(exp_we));
    chk(idx_err == exp_err, "R8 idx_err", 96'(idx_err), 96'(exp_err));
    if (exp_we && mem_we) begin
      chk(int'(mem_addr) == exp_addr, "R7 mem_addr", 96'(mem_addr), 96'(exp_addr));
      dreq = m_f32 ? "R2/R4/R5/R6 f32 vector" : "R3 packed vector";
      chk(mem_wdata == exp_v, dreq, mem_wdata, exp_v);
    end
  endtask

  function automatic logic [31:0] rnd_word();
    int sel = $urandom_range(0, 5);
    logic [31:0] w = $urandom;
    case (sel)
      0: w[30:23] = 8'(63 + $urandom_range(0, 3));
      1: w[30:23] = 8'(190 + $urandom_range(0, 3));
      2: w[30:23] = 8'hFF;
      3: w[30:23] = 8'h00;
      default: ;
    endcase
    return w;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!mem_we && !idx_err, "R10 reset outputs", {mem_we, idx_err}, 96'h0);

    // R10 reset state: packed, index 0; R3 literal unpack
    wr(4'd9, 32'h11223344);
    wr(4'd15, 32'h55667788);
    wr(4'd8, 32'h99AABBCC);
    chk(mem_wdata == 96'h112233445566778899AABBCC, "R3 literal packed",
        mem_wdata, 96'h112233445566778899AABBCC);

    // R2 R4 R5 literal single-precision, reversed components
    wr(4'd0, 32'h8000_0005);
    wr(4'd10, 32'h3F800000);
    wr(4'd3, 32'hDEADBEEF);           // R1: undecoded address ignored
    wr(4'd11, 32'hC0000000);
    wr(4'd12, 32'h00000000);
    wr(4'd13, 32'h80000000);
    chk(mem_wdata == 96'h3F0000_C00000_000000_800000 && mem_addr == 7'd5,
        "R2 literal f32", mem_wdata, 96'h3F0000_C00000_000000_800000);

    // R5 R6 R4 exponent edges, index 6
    wr(4'd14, 32'h7F800000);
    wr(4'd14, 32'h20000000);
    wr(4'd14, 32'h20800000);
    wr(4'd14, 32'h60000000);
    chk(mem_wdata == 96'h7FFFFF_000000_010000_7FFFFF && mem_addr == 7'd6,
        "R6 R5 literal edges", mem_wdata, 96'h7FFFFF_000000_010000_7FFFFF);
    wr(4'd8, 32'h5F800000);
    wr(4'd8, 32'hA0000000);
    wr(4'd8, 32'h5FFFFFFF);
    wr(4'd8, 32'h20FFFFFF);
    chk(mem_wdata == 96'h7F0000_800000_7FFFFF_01FFFF, "R4 literal edges",
        mem_wdata, 96'h7F0000_800000_7FFFFF_01FFFF);

    // R7 R8 slot 95 accepted, 96 rejected twice (index held)
    wr(4'd0, 32'h8000_005F);
    for (int k = 0; k < 12; k++) wr(4'(8 + k % 8), rnd_word());

    // R9 setup mid-vector discards staged words
    wr(4'd0, 32'h0000_000A);
    wr(4'd8, 32'hAAAAAAAA);
    wr(4'd9, 32'hBBBBBBBB);
    wr(4'd0, 32'h0000_0014);
    wr(4'd8, 32'h01020304);
    wr(4'd9, 32'h05060708);
    wr(4'd10, 32'h090A0B0C);
    chk(mem_addr == 7'd20 && mem_wdata == 96'h0102030405060708090A0B0C,
        "R9 restaged vector", mem_wdata, 96'h0102030405060708090A0B0C);

    // R8 index 127
    wr(4'd0, 32'h0000_007F);
    for (int k = 0; k < 3; k++) wr(4'd12, $urandom);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 99);
      if (r < 8) begin
        logic [31:0] s = $urandom;
        s[6:0] = ($urandom_range(0, 1) == 1) ? 7'($urandom_range(88, 100))
                                             : 7'($urandom_range(0, 127));
        wr(4'd0, s);
      end else if (r < 18) begin
        wr(4'($urandom_range(1, 7)), $urandom);
      end else if (r < 23) begin
        @(negedge clk);
        chk(!mem_we && !idx_err, "R1 idle no output", {mem_we, idx_err}, 96'h0);
      end else begin
        wr(4'($urandom_range(8, 15)), rnd_word());
      end
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule